// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block gives the fetch stage a predicted next PC in the same cycle that the fetch PC is presented, before the instruction has been decoded. It is a direct-mapped table of 2^IDX_W entries. Each entry holds a valid flag, the full PC of a control instruction and the target that instruction last jumped to. A lookup selects one entry using a slice of the fetch PC and compares the stored PC with the whole fetch PC. On a match the stored target is the prediction. On any other outcome the prediction is the sequential address, fetch PC plus INSTR_BYTES.

The table changes only through the resolve port, which the execute stage drives once a control instruction has its final outcome. A control transfer that resolves taken writes its PC and target into its entry. A control instruction that resolves not-taken removes its entry, but only if that entry really holds its PC. The resolve port also compares the prediction that travelled down the pipeline with the actual next PC and flags a mispredict in the same cycle. Because the whole PC is kept as a tag, a non-branch instruction that shares an index with a branch is never redirected.

Top module: `btb_direct`

## Requirements
- R1: When the selected entry is valid and its stored PC equals `fetch_pc`, `pred_hit` is 1 and `pred_npc` equals the stored target, combinationally.
- R2: When there is no such match, `pred_hit` is 0 and `pred_npc` equals `fetch_pc + INSTR_BYTES` (4 by default).
- R3: The entry index is `fetch_pc[IDX_LSB +: IDX_W]` (bits 6:0 by default, 128 entries). PCs 1028 and 132 share entry 4, and only the one whose PC is stored there hits.
- R4: The table does not change in a cycle unless `upd_valid` and `upd_ctrl` are both 1. A resolve of a non-control instruction never writes it.
- R5: A resolve with `upd_valid`, `upd_ctrl` and `upd_taken` at 1 writes valid, `upd_pc` and `upd_target` into the entry of `upd_pc` at the clock edge. Any previous occupant of that entry is replaced.
- R6: A not-taken control resolve whose entry is valid and holds `upd_pc` clears that entry's valid flag at the clock edge.
- R7: A not-taken control resolve whose PC is not the one stored in its entry leaves the entry unchanged.
- R8: `upd_mispredict` is 1 exactly when `upd_valid` is 1 and `upd_pred_npc` differs from the actual next PC. The actual next PC is `upd_target` for a taken control instruction and `upd_pc + INSTR_BYTES` otherwise. The flag is combinational in the same cycle.
- R9: Reset (`rst_n` low) clears every valid flag, so all lookups miss afterwards.
- R10: A lookup and a resolve in the same cycle that touch the same entry give a lookup result from the contents held before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | PC being fetched |
| pred_npc | output | PC_W | Predicted next fetch PC |
| pred_hit | output | 1 | Lookup matched a valid entry |
| upd_valid | input | 1 | A resolved instruction is presented |
| upd_ctrl | input | 1 | Resolved instruction is a branch or jump |
| upd_taken | input | 1 | Resolved control instruction was taken |
| upd_pc | input | PC_W | PC of the resolved instruction |
| upd_target | input | PC_W | Actual target of the resolved instruction |
| upd_pred_npc | input | PC_W | Next PC that was predicted for it at fetch |
| upd_mispredict | output | 1 | Predicted next PC differs from actual next PC |

## Verification
A lookup at fetch and a write from the resolve port can fall in the same cycle and on the same entry. The bench provokes this by presenting the fetch PC of an entry while resolving that same PC as taken, or as not-taken so that the entry is deleted. A scoreboard model keeps its table update until after it has predicted the lookup. It therefore expects the old hit or miss in that cycle and the new contents from the next cycle on.

// File: rtl/btb_pkg.sv
package btb_pkg;
   typedef enum logic [1:0] {
      OP_KEEP  = 2'd0,
      OP_WRITE = 2'd1,
      OP_DROP  = 2'd2
   } btb_op_e;
endpackage

// File: rtl/btb_store.sv
module btb_store
   import btb_pkg::*;
#(
   parameter int PC_W       = 32,
   parameter int IDX_W      = 7,
   parameter bit RESET_DATA = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [PC_W-1:0]  rd_tag,
   output logic [PC_W-1:0]  rd_tgt,
   input  logic [IDX_W-1:0] chk_idx,
   output logic             chk_valid,
   output logic [PC_W-1:0]  chk_tag,
   input  btb_op_e          wr_op,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [PC_W-1:0]  wr_tag,
   input  logic [PC_W-1:0]  wr_tgt
);
   localparam int DEPTH = 1 << IDX_W;

   logic [DEPTH-1:0] valid_q;
   logic [PC_W-1:0]  tag_q [DEPTH];
   logic [PC_W-1:0]  tgt_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      logic sel;
      assign sel = (wr_idx == IDX_W'(e));

      always_ff @(posedge clk) begin
         if (!rst_n)
            valid_q[e] <= 1'b0;
         else if (sel && wr_op == OP_WRITE)
            valid_q[e] <= 1'b1;
         else if (sel && wr_op == OP_DROP)
            valid_q[e] <= 1'b0;
      end

      if (RESET_DATA) begin : g_rst_data
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               tag_q[e] <= '0;
               tgt_q[e] <= '0;
            end else if (sel && wr_op == OP_WRITE) begin
               tag_q[e] <= wr_tag;
               tgt_q[e] <= wr_tgt;
            end
         end
      end else begin : g_plain_data
         always_ff @(posedge clk) begin
            if (sel && wr_op == OP_WRITE) begin
               tag_q[e] <= wr_tag;
               tgt_q[e] <= wr_tgt;
            end
         end
      end
   end

   assign rd_valid  = valid_q[rd_idx];
   assign rd_tag    = tag_q[rd_idx];
   assign rd_tgt    = tgt_q[rd_idx];
   assign chk_valid = valid_q[chk_idx];
   assign chk_tag   = tag_q[chk_idx];

   // R5: a write leaves a valid entry holding the written PC and target
   assert_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_op == OP_WRITE |=> valid_q[$past(wr_idx)]
                            && tag_q[$past(wr_idx)] == $past(wr_tag)
                            && tgt_q[$past(wr_idx)] == $past(wr_tgt));

   // R6: a drop leaves the entry invalid
   assert_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_op == OP_DROP |=> !valid_q[$past(wr_idx)]);

   // R4: without an operation the valid flags hold
   assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_op == OP_KEEP |=> $stable(valid_q));
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
   parameter int PC_W        = 32,
   parameter int IDX_W       = 7,
   parameter int IDX_LSB     = 0,
   parameter int INSTR_BYTES = 4
) (
   input  logic [PC_W-1:0]  fetch_pc,
   output logic [IDX_W-1:0] idx,
   input  logic             ent_valid,
   input  logic [PC_W-1:0]  ent_tag,
   input  logic [PC_W-1:0]  ent_tgt,
   output logic             hit,
   output logic [PC_W-1:0]  npc
);
   localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

   logic [PC_W-1:0] seq_pc;

   assign idx    = fetch_pc[IDX_LSB +: IDX_W];
   assign seq_pc = fetch_pc + STEP;

   always_comb begin
      hit = ent_valid && (ent_tag == fetch_pc);
      npc = hit ? ent_tgt : seq_pc;
   end
endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
   import btb_pkg::*;
#(
   parameter int PC_W        = 32,
   parameter int IDX_W       = 7,
   parameter int IDX_LSB     = 0,
   parameter int INSTR_BYTES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_valid,
   input  logic             upd_ctrl,
   input  logic             upd_taken,
   input  logic [PC_W-1:0]  upd_pc,
   input  logic [PC_W-1:0]  upd_target,
   input  logic [PC_W-1:0]  upd_pred_npc,
   output logic [IDX_W-1:0] idx,
   input  logic             ent_valid,
   input  logic [PC_W-1:0]  ent_tag,
   output btb_op_e          op,
   output logic             mispredict
);
   localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

   logic            ctrl_ev;
   logic            present;
   logic [PC_W-1:0] actual_npc;

   assign idx     = upd_pc[IDX_LSB +: IDX_W];
   assign ctrl_ev = upd_valid && upd_ctrl;
   assign present = ent_valid && (ent_tag == upd_pc);

   always_comb begin
      actual_npc = (upd_ctrl && upd_taken) ? upd_target : upd_pc + STEP;
      mispredict = upd_valid && (upd_pred_npc != actual_npc);
   end

   always_comb begin
      op = OP_KEEP;
      if (ctrl_ev) begin
         if (upd_taken)    op = OP_WRITE;
         else if (present) op = OP_DROP;
      end
   end

   // R8: a taken transfer predicted at its own target is never a mispredict
   assert_taken_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_ev && upd_taken && upd_pred_npc == upd_target) |-> !mispredict);

   // R7: an absent not-taken branch never deletes anything
   assert_no_stray_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_ev && !upd_taken && ent_tag != upd_pc) |-> op == OP_KEEP);
endmodule

// File: rtl/btb_direct.sv
module btb_direct
   import btb_pkg::*;
#(
   parameter int PC_W        = 32,
   parameter int IDX_W       = 7,
   parameter int IDX_LSB     = 0,
   parameter int INSTR_BYTES = 4,
   parameter bit RESET_DATA  = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   output logic [PC_W-1:0] pred_npc,
   output logic            pred_hit,
   input  logic            upd_valid,
   input  logic            upd_ctrl,
   input  logic            upd_taken,
   input  logic [PC_W-1:0] upd_pc,
   input  logic [PC_W-1:0] upd_target,
   input  logic [PC_W-1:0] upd_pred_npc,
   output logic            upd_mispredict
);
   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
      $error("btb_direct: IDX_W must lie in 1..12");
   end
   if (IDX_LSB < 0 || IDX_LSB + IDX_W > PC_W) begin : g_bad_lsb
      $error("btb_direct: index slice exceeds the PC");
   end
   if (INSTR_BYTES < 1) begin : g_bad_step
      $error("btb_direct: INSTR_BYTES must be positive");
   end

   localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

   logic [IDX_W-1:0] rd_idx, chk_idx;
   logic             rd_valid, chk_valid;
   logic [PC_W-1:0]  rd_tag, rd_tgt, chk_tag;
   btb_op_e          op;

   btb_lookup #(
      .PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB), .INSTR_BYTES(INSTR_BYTES)
   ) u_lookup (
      .fetch_pc  (fetch_pc),
      .idx       (rd_idx),
      .ent_valid (rd_valid),
      .ent_tag   (rd_tag),
      .ent_tgt   (rd_tgt),
      .hit       (pred_hit),
      .npc       (pred_npc)
   );

   btb_resolve #(
      .PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB), .INSTR_BYTES(INSTR_BYTES)
   ) u_resolve (
      .clk          (clk),
      .rst_n        (rst_n),
      .upd_valid    (upd_valid),
      .upd_ctrl     (upd_ctrl),
      .upd_taken    (upd_taken),
      .upd_pc       (upd_pc),
      .upd_target   (upd_target),
      .upd_pred_npc (upd_pred_npc),
      .idx          (chk_idx),
      .ent_valid    (chk_valid),
      .ent_tag      (chk_tag),
      .op           (op),
      .mispredict   (upd_mispredict)
   );

   btb_store #(
      .PC_W(PC_W), .IDX_W(IDX_W), .RESET_DATA(RESET_DATA)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (rd_idx),
      .rd_valid  (rd_valid),
      .rd_tag    (rd_tag),
      .rd_tgt    (rd_tgt),
      .chk_idx   (chk_idx),
      .chk_valid (chk_valid),
      .chk_tag   (chk_tag),
      .wr_op     (op),
      .wr_idx    (chk_idx),
      .wr_tag    (upd_pc),
      .wr_tgt    (upd_target)
   );

   // R2: a miss always falls through to the sequential address
   assert_miss_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_hit |-> pred_npc == fetch_pc + STEP);

   // R5: a taken resolve makes the same PC hit its target next cycle
   assert_hit_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_ctrl && upd_taken) ##1 (fetch_pc == $past(upd_pc))
         |-> pred_hit && pred_npc == $past(upd_target));
endmodule

// File: tb/tb_btb_direct.sv
`timescale 1ns/1ps
module tb_btb_direct;
   localparam int PC_W  = 32;
   localparam int IDX_W = 7;
   localparam int DEPTH = 1 << IDX_W;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [PC_W-1:0] fetch_pc = '0;
   logic [PC_W-1:0] pred_npc;
   logic            pred_hit;
   logic            upd_valid = 1'b0, upd_ctrl = 1'b0, upd_taken = 1'b0;
   logic [PC_W-1:0] upd_pc = '0, upd_target = '0, upd_pred_npc = '0;
   logic            upd_mispredict;

   always #2.5 clk = ~clk;

   btb_direct #(.PC_W(PC_W), .IDX_W(IDX_W)) dut (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_npc(pred_npc),
      .pred_hit(pred_hit), .upd_valid(upd_valid), .upd_ctrl(upd_ctrl),
      .upd_taken(upd_taken), .upd_pc(upd_pc), .upd_target(upd_target),
      .upd_pred_npc(upd_pred_npc), .upd_mispredict(upd_mispredict)
   );

   typedef struct {
      logic [PC_W-1:0] npc;
      logic            hit;
      logic            chk_mp;
      logic            mp;
      string           req;
   } exp_t;

   exp_t            sb[$];
   event            sample_ev;
   int              checks = 0;
   int              errors = 0;
   bit              done = 1'b0;

   logic            m_v [DEPTH];
   logic [PC_W-1:0] m_t [DEPTH];
   logic [PC_W-1:0] m_g [DEPTH];

   function automatic void model_clear();
      for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
   endfunction

   task automatic step(input logic [PC_W-1:0] fpc, input logic rv, input logic ctl,
                       input logic tk, input logic [PC_W-1:0] rpc,
                       input logic [PC_W-1:0] rtg, input logic [PC_W-1:0] rpn,
                       input string req);
      exp_t e;
      int fi, ri;
      logic [PC_W-1:0] act;
      @(negedge clk);
      fetch_pc = fpc; upd_valid = rv; upd_ctrl = ctl; upd_taken = tk;
      upd_pc = rpc; upd_target = rtg; upd_pred_npc = rpn;
      fi = int'(fpc[IDX_W-1:0]);
      ri = int'(rpc[IDX_W-1:0]);
      e.hit = m_v[fi] && (m_t[fi] == fpc);
      e.npc = e.hit ? m_g[fi] : fpc + 4;
      act = (ctl && tk) ? rtg : rpc + 4;
      e.chk_mp = rv;
      e.mp = rv && (rpn != act);
      e.req = req;
      sb.push_back(e);
      #1 ->sample_ev;
      if (rv && ctl) begin
         if (tk) begin
            m_v[ri] = 1'b1; m_t[ri] = rpc; m_g[ri] = rtg;
         end else if (m_v[ri] && m_t[ri] == rpc) begin
            m_v[ri] = 1'b0;
         end
      end
   endtask

   task automatic look(input logic [PC_W-1:0] fpc, input string req);
      step(fpc, 1'b0, 1'b0, 1'b0, '0, '0, '0, req);
   endtask

   initial begin
      exp_t e;
      forever begin
         @(sample_ev);
         e = sb.pop_front();
         checks++;
         if (pred_hit !== e.hit || pred_npc !== e.npc) begin
            errors++;
            $display("FAIL %s: hit=%0b npc=%0d expected hit=%0b npc=%0d",
                     e.req, pred_hit, pred_npc, e.hit, e.npc);
         end
         if (e.chk_mp) begin
            checks++;
            if (upd_mispredict !== e.mp) begin
               errors++;
               $display("FAIL %s: mispredict=%0b expected %0b",
                        e.req, upd_mispredict, e.mp);
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run not finished, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9: nothing hits after reset; R2 sequential fall-through
      look(32'd1028, "R9");
      // R10 + R8: taken insert of 1028->236, lookup sees old miss, mispredict set
      step(32'd1028, 1, 1, 1, 32'd1028, 32'd236, 32'd1032, "R10");
      // R1/R5: now hits
      look(32'd1028, "R5");
      // R3: 132 shares entry 4 but misses; R4/R8 non-control resolve, correct prediction
      step(32'd132, 1, 0, 0, 32'd132, 32'd0, 32'd136, "R3");
      // R4: resolve without upd_valid writes nothing
      step(32'd1028, 0, 1, 1, 32'd1028, 32'd700, 32'd0, "R4");
      look(32'd1028, "R4");
      // R7: not-taken branch at 132 is absent and must not delete 1028
      step(32'd1028, 1, 1, 0, 32'd132, 32'd0, 32'd136, "R7");
      look(32'd1028, "R7");
      // R10 + R6: delete 1028 while looking it up; old hit seen, mispredict set
      step(32'd1028, 1, 1, 0, 32'd1028, 32'd0, 32'd236, "R10");
      look(32'd1028, "R6");
      // R5 replacement at entry 4 by 132->500, R8 mispredict
      step(32'd64, 1, 1, 1, 32'd132, 32'd500, 32'd136, "R8");
      look(32'd132, "R1");
      step(32'd1028, 1, 1, 1, 32'd132, 32'd500, 32'd500, "R3");
      // R5: second entry at index 80
      step(32'd132, 1, 1, 1, 32'd2000, 32'd3000, 32'd2004, "R5");
      look(32'd2000, "R1");
      look(32'd2001, "R2");
      // R9: reset in mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      model_clear();
      look(32'd132, "R9");
      look(32'd2000, "R9");
      @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule